// File: doc/BRIEF.md
# Chip-Select Triggered UART Word Sender

This block delivers a 16-bit conversion result to a distant UART receiver as two separate asynchronous characters. The receiving side supplies a serial clock that fixes the bit rate, and it asks for each character by pulling an active-low select line low. The block sends the upper byte on the first request and the lower byte on the second. Each character has one low start bit, eight data bits with the least significant bit first, and two high stop bits. After the last stop bit the serial output is released to high impedance through its output-enable.

A result arrives on a parallel word input together with a one-cycle valid strobe. The block keeps it in a holding register and raises data-ready. A word that arrives while a character is on the line is dropped. A word that arrives in the idle gap between the two characters replaces the held one, and the next character then carries the upper byte of the new word. All sequential logic runs on the falling edge of the serial clock.

Top module: `cs_uart_word_tx`

## Requirements
- R1: During and after reset, with no select activity, `sdo_oe` is 0, `data_rdy` is 0 and `sdo` is 1.
- R2: A character starts on a falling edge of `sclk` at which `cs_n` is sampled low, provided no character is in progress and `cs_n` has been sampled high at some falling edge since the previous start (always true after reset). From that edge `sdo_oe` is 1 and `sdo` carries the start bit.
- R3: A character is 11 bit periods, one per `sclk` period, and `sdo` changes only on falling edges. Bit 0 is the start bit (0), bits 1 to 8 are data bits 0 to 7 of the byte (least significant first), and bits 9 and 10 are stop bits (1).
- R4: On the falling edge one period after the second stop bit begins, `sdo_oe` returns to 0, which is 11 periods after the start edge.
- R5: The first character after a word is loaded carries word bits 15 to 8. The next one carries bits 7 to 0.
- R6: If `cs_n` stays low after a character ends, no further character starts until `cs_n` has been sampled high on a falling edge and then sampled low again.
- R7: A `word_valid` strobe sampled while a character is in progress, or on the edge that starts one, is ignored: neither byte of the characters that follow changes.
- R8: A `word_valid` strobe sampled while no character is in progress loads `word_in` into the holding register and selects the upper byte. This applies in the gap between the two characters too.
- R9: `data_rdy` rises on the edge that loads a word, stays 1 through the upper-byte character and falls when the lower-byte character ends.
- R10: The byte select toggles after every complete character, so a third request without a new load sends the upper byte of the same word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the receiver. All state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | 16 | Result word to be sent |
| word_valid | input | 1 | One-cycle strobe marking a new word on `word_in` |
| cs_n | input | 1 | Active-low select. Low on a falling edge requests a character |
| data_rdy | output | 1 | High while an unsent or half-sent word is held |
| sdo | output | 1 | Serial data. Driven when `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable. 0 means the line is at high impedance |

## Verification
The assertions assume that `cs_n`, `word_valid` and `word_in` are synchronous to the falling edge of `sclk`, so each input has a single defined value at every falling edge, and that `word_valid` is a strobe rather than a level. The bench changes every input one time unit after a rising edge and reads the outputs on rising edges, half a period away from any edge where the design updates. Word strobes are aimed at chosen bit positions of a character, including the start edge, the middle and the idle gap, so that the drop and overwrite windows are exercised at their borders.

// File: rtl/cuwt_pkg.sv
package cuwt_pkg;

  // Widest byte that the frame bit function accepts.
  localparam int unsigned MAX_W = 32;

  typedef enum logic {
    SEL_UPPER = 1'b0,
    SEL_LOWER = 1'b1
  } byte_sel_e;

  // Value of line bit `pos` of a character carrying `data`:
  // position 0 is the start bit, 1..byte_w are data (LSB first), rest are stop.
  function automatic logic frame_bit(input logic [MAX_W-1:0] data,
                                     input int unsigned      pos,
                                     input int unsigned      byte_w);
    logic r;
    r = 1'b1;
    if (pos == 0) begin
      r = 1'b0;
    end else begin
      for (int i = 0; i < MAX_W; i++) begin
        if ((i + 1) == pos && pos <= byte_w) r = data[i];
      end
    end
    return r;
  endfunction

  function automatic byte_sel_e flip_sel(input byte_sel_e s);
    return (s == SEL_UPPER) ? SEL_LOWER : SEL_UPPER;
  endfunction

endpackage

// File: rtl/cuwt_cs_gate.sv
module cuwt_cs_gate (
  input  logic sclk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic busy_i,
  output logic start_o
);

  logic armed_q;

  // Start needs an idle line, a low select, and a high select seen since the last start.
  assign start_o = !cs_n && armed_q && !busy_i;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
    end else if (start_o) begin
      armed_q <= 1'b0;
    end else if (cs_n) begin
      armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/cuwt_frame_shifter.sv
module cuwt_frame_shifter
  import cuwt_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned STOP_BITS = 2,
  localparam int unsigned FRAME_LEN = 1 + BYTE_W + STOP_BITS,
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              sdo_o,
  output logic              oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic              busy_q;
  logic              oe_q;
  logic              sdo_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [MAX_W-1:0]  shreg_ext;
  logic [MAX_W-1:0]  byte_ext;

  always_comb begin
    shreg_ext = '0;
    shreg_ext[BYTE_W-1:0] = shreg_q;
    byte_ext = '0;
    byte_ext[BYTE_W-1:0] = byte_i;
  end

  // The edge that closes the frame is the one after the last stop bit began.
  assign done_o = busy_q && (idx_q == LAST_IDX);

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      oe_q    <= 1'b0;
      sdo_q   <= 1'b1;
      idx_q   <= '0;
      shreg_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      oe_q    <= 1'b1;
      idx_q   <= '0;
      shreg_q <= byte_i;
      sdo_q   <= frame_bit(byte_ext, 0, BYTE_W);
    end else if (done_o) begin
      busy_q  <= 1'b0;
      oe_q    <= 1'b0;
      sdo_q   <= 1'b1;
      idx_q   <= '0;
    end else if (busy_q) begin
      idx_q   <= idx_q + 1'b1;
      sdo_q   <= frame_bit(shreg_ext, int'(idx_q) + 1, BYTE_W);
    end
  end

  assign sdo_o  = sdo_q;
  assign oe_o   = oe_q;
  assign busy_o = busy_q;
  assign idx_o  = idx_q;

endmodule

// File: rtl/cuwt_hold_ctrl.sv
module cuwt_hold_ctrl
  import cuwt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned BYTE_W = DATA_W / 2
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word_i,
  input  logic              word_valid_i,
  input  logic              busy_i,
  input  logic              start_i,
  input  logic              done_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              rdy_o,
  output logic              accept_o,
  output byte_sel_e         sel_o,
  output logic [DATA_W-1:0] hold_o
);

  logic [DATA_W-1:0] hold_q;
  byte_sel_e         sel_q;
  logic              rdy_q;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [DATA_W-1:0] w,
                                                  input byte_sel_e         s);
    return (s == SEL_UPPER) ? w[DATA_W-1 -: BYTE_W] : w[BYTE_W-1:0];
  endfunction

  // A word is taken only while the line is quiet and no frame is launching.
  assign accept_o = word_valid_i && !busy_i && !start_i;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sel_q  <= SEL_UPPER;
      rdy_q  <= 1'b0;
    end else if (accept_o) begin
      hold_q <= word_i;
      sel_q  <= SEL_UPPER;
      rdy_q  <= 1'b1;
    end else if (done_i) begin
      sel_q  <= flip_sel(sel_q);
      if (sel_q == SEL_LOWER) rdy_q <= 1'b0;
    end
  end

  assign byte_o = pick_byte(hold_q, sel_q);
  assign rdy_o  = rdy_q;
  assign sel_o  = sel_q;
  assign hold_o = hold_q;

endmodule

// File: rtl/cs_uart_word_tx.sv
module cs_uart_word_tx
  import cuwt_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned STOP_BITS = 2,
  localparam int unsigned BYTE_W    = DATA_W / 2,
  localparam int unsigned FRAME_LEN = 1 + BYTE_W + STOP_BITS,
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word_in,
  input  logic              word_valid,
  input  logic              cs_n,
  output logic              data_rdy,
  output logic              sdo,
  output logic              sdo_oe
);

  // Named internal events, brought out for the checker.
  logic              start_evt;
  logic              done_evt;
  logic              accept_evt;
  logic              busy;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] hold_q;
  byte_sel_e         sel_q;
  logic [BYTE_W-1:0] tx_byte;

  cuwt_cs_gate gate_i (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .busy_i  (busy),
    .start_o (start_evt)
  );

  cuwt_hold_ctrl #(
    .DATA_W (DATA_W)
  ) hold_i (
    .sclk         (sclk),
    .rst_n        (rst_n),
    .word_i       (word_in),
    .word_valid_i (word_valid),
    .busy_i       (busy),
    .start_i      (start_evt),
    .done_i       (done_evt),
    .byte_o       (tx_byte),
    .rdy_o        (data_rdy),
    .accept_o     (accept_evt),
    .sel_o        (sel_q),
    .hold_o       (hold_q)
  );

  cuwt_frame_shifter #(
    .BYTE_W    (BYTE_W),
    .STOP_BITS (STOP_BITS)
  ) shift_i (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .start_i (start_evt),
    .byte_i  (tx_byte),
    .sdo_o   (sdo),
    .oe_o    (sdo_oe),
    .busy_o  (busy),
    .done_o  (done_evt),
    .idx_o   (bit_idx)
  );

endmodule

// File: rtl/cuwt_sva.sv
module cuwt_sva #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned STOP_BITS = 2,
  localparam int unsigned BYTE_W    = DATA_W / 2,
  localparam int unsigned FRAME_LEN = 1 + BYTE_W + STOP_BITS,
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
  input logic              sclk,
  input logic              rst_n,
  input logic [DATA_W-1:0] word_in,
  input logic              word_valid,
  input logic              cs_n,
  input logic              data_rdy,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              start_evt,
  input logic              done_evt,
  input logic              accept_evt,
  input logic              busy,
  input logic [IDX_W-1:0]  bit_idx,
  input logic [DATA_W-1:0] hold_q,
  input logic              sel_q
);

  localparam logic [IDX_W-1:0] FIRST_STOP = IDX_W'(1 + BYTE_W);

  assert_start_on_low_cs_R2: assert property (@(negedge sclk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !$past(cs_n));

  assert_start_bit_low_R3: assert property (@(negedge sclk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  assert_stop_bits_high_R3: assert property (@(negedge sclk) disable iff (!rst_n)
    (sdo_oe && bit_idx >= FIRST_STOP) |-> sdo);

  assert_release_after_stop_R4: assert property (@(negedge sclk) disable iff (!rst_n)
    done_evt |=> !sdo_oe);

  assert_launch_drives_R2: assert property (@(negedge sclk) disable iff (!rst_n)
    start_evt |=> (sdo_oe && busy));

  assert_drop_in_frame_R7: assert property (@(negedge sclk) disable iff (!rst_n)
    ((busy || start_evt) && word_valid) |=> $stable(hold_q));

  assert_load_idle_R8: assert property (@(negedge sclk) disable iff (!rst_n)
    accept_evt |=> (hold_q == $past(word_in)) && !sel_q && data_rdy);

  assert_rdy_clear_R9: assert property (@(negedge sclk) disable iff (!rst_n)
    (done_evt && sel_q) |=> !data_rdy);

  assert_sel_toggle_R10: assert property (@(negedge sclk) disable iff (!rst_n)
    done_evt |=> (sel_q != $past(sel_q)));

endmodule

bind cs_uart_word_tx cuwt_sva #(
  .DATA_W    (DATA_W),
  .STOP_BITS (STOP_BITS)
) sva_i (
  .sclk       (sclk),
  .rst_n      (rst_n),
  .word_in    (word_in),
  .word_valid (word_valid),
  .cs_n       (cs_n),
  .data_rdy   (data_rdy),
  .sdo        (sdo),
  .sdo_oe     (sdo_oe),
  .start_evt  (start_evt),
  .done_evt   (done_evt),
  .accept_evt (accept_evt),
  .busy       (busy),
  .bit_idx    (bit_idx),
  .hold_q     (hold_q),
  .sel_q      (sel_q)
);

// File: tb/cs_uart_word_tx_tb.sv
`timescale 1ns/1ps
module cs_uart_word_tx_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word_in = '0;
  logic        word_valid = 1'b0;
  logic        cs_n = 1'b1;
  logic        data_rdy;
  logic        sdo;
  logic        sdo_oe;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) sclk = ~sclk;

  cs_uart_word_tx dut_i (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .word_in    (word_in),
    .word_valid (word_valid),
    .cs_n       (cs_n),
    .data_rdy   (data_rdy),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Expected line pattern, bit i is line bit i: start 0, data LSB first, two stops.
  function automatic logic [10:0] expect_frame(input logic [7:0] b);
    logic [10:0] f;
    f = 11'h600;
    for (int i = 0; i < 8; i++) f[i + 1] = b[i];
    return f;
  endfunction

  task automatic step();
    @(posedge sclk);
    #1;
  endtask

  task automatic load(input logic [15:0] w);
    word_in    = w;
    word_valid = 1'b1;
    step();
    word_valid = 1'b0;
  endtask

  // Requests one character; samples on rising edges, drives 1 unit later.
  task automatic get_frame(input logic keep_low, input logic inj_mid,
                           input logic inj_start, input logic [15:0] inj_word,
                           output logic [10:0] bits, output logic all_oe,
                           output logic oe_after);
    all_oe = 1'b1;
    cs_n = 1'b0;
    if (inj_start) begin
      word_in    = inj_word;
      word_valid = 1'b1;
    end
    for (int i = 0; i < 11; i++) begin
      @(posedge sclk);
      bits[i] = sdo;
      all_oe  = all_oe & sdo_oe;
      #1;
      if (i == 0) begin
        word_valid = 1'b0;
        if (!keep_low) cs_n = 1'b1;
      end
      if (inj_mid && i == 3) begin
        word_in    = inj_word;
        word_valid = 1'b1;
      end
      if (inj_mid && i == 4) word_valid = 1'b0;
    end
    @(posedge sclk);
    oe_after = sdo_oe;
    #1;
  endtask

  task automatic frame_check(input string req, input logic [7:0] exp_b,
                             input logic keep_low, input logic inj_mid,
                             input logic inj_start, input logic [15:0] inj_word);
    logic [10:0] bits;
    logic all_oe, oe_after;
    get_frame(keep_low, inj_mid, inj_start, inj_word, bits, all_oe, oe_after);
    chk(bits == expect_frame(exp_b), req, "frame bits (R3)", 32'(bits),
        32'(expect_frame(exp_b)));
    chk(all_oe === 1'b1, "R2", "output enabled for whole frame", 32'(all_oe), 32'd1);
    chk(oe_after === 1'b0, "R4", "output released after stop", 32'(oe_after), 32'd0);
  endtask

  initial begin
    logic [15:0] w;
    logic [15:0] a;
    logic [15:0] b;
    repeat (3) step();
    chk(sdo_oe === 1'b0, "R1", "oe in reset", 32'(sdo_oe), 32'd0);
    chk(data_rdy === 1'b0, "R1", "rdy in reset", 32'(data_rdy), 32'd0);
    chk(sdo === 1'b1, "R1", "sdo in reset", 32'(sdo), 32'd1);
    rst_n = 1'b1;
    repeat (4) step();
    chk(sdo_oe === 1'b0, "R1", "idle with cs high", 32'(sdo_oe), 32'd0);

    // Sweep: walking ones, then an arithmetic series of words.
    for (int n = 0; n < 80; n++) begin
      w = (n < 16) ? (16'h1 << n) : 16'((n * 40503 + 12345) & 16'hffff);
      load(w);
      chk(data_rdy === 1'b1, "R9", "rdy after load", 32'(data_rdy), 32'd1);
      frame_check("R5", w[15:8], 1'b0, 1'b0, 1'b0, 16'h0);
      chk(data_rdy === 1'b1, "R9", "rdy after upper", 32'(data_rdy), 32'd1);
      frame_check("R5", w[7:0], 1'b0, 1'b0, 1'b0, 16'h0);
      chk(data_rdy === 1'b0, "R9", "rdy after lower", 32'(data_rdy), 32'd0);
      step();
    end

    // R10: third request repeats the upper byte.
    a = 16'hC13E;
    load(a);
    frame_check("R10", a[15:8], 1'b0, 1'b0, 1'b0, 16'h0);
    frame_check("R10", a[7:0], 1'b0, 1'b0, 1'b0, 16'h0);
    frame_check("R10", a[15:8], 1'b0, 1'b0, 1'b0, 16'h0);
    chk(data_rdy === 1'b0, "R10", "rdy stays low on repeat", 32'(data_rdy), 32'd0);

    // R6: select held low after a frame gives no new frame.
    a = 16'h5AF0;
    load(a);
    frame_check("R6", a[15:8], 1'b1, 1'b0, 1'b0, 16'h0);
    for (int i = 0; i < 15; i++) begin
      @(posedge sclk);
      chk(sdo_oe === 1'b0, "R6", "no restart while cs low", 32'(sdo_oe), 32'd0);
      #1;
    end
    cs_n = 1'b1;
    step();
    frame_check("R6", a[7:0], 1'b0, 1'b0, 1'b0, 16'h0);

    // R7: word in the middle of a frame is dropped.
    a = 16'hA5C3;
    b = 16'h3C5A;
    load(a);
    frame_check("R7", a[15:8], 1'b0, 1'b1, 1'b0, b);
    frame_check("R7", a[7:0], 1'b0, 1'b0, 1'b0, 16'h0);
    chk(data_rdy === 1'b0, "R7", "dropped word sets no rdy", 32'(data_rdy), 32'd0);

    // R7: word on the start edge is dropped.
    a = 16'h9261;
    b = 16'h7F08;
    load(a);
    frame_check("R7", a[15:8], 1'b0, 1'b0, 1'b1, b);
    frame_check("R7", a[7:0], 1'b0, 1'b0, 1'b0, 16'h0);

    // R8: word in the gap overwrites, next frame is the new upper byte.
    a = 16'h1234;
    b = 16'hFEDC;
    load(a);
    frame_check("R8", a[15:8], 1'b0, 1'b0, 1'b0, 16'h0);
    load(b);
    chk(data_rdy === 1'b1, "R8", "rdy after gap load", 32'(data_rdy), 32'd1);
    frame_check("R8", b[15:8], 1'b0, 1'b0, 1'b0, 16'h0);
    frame_check("R8", b[7:0], 1'b0, 1'b0, 1'b0, 16'h0);
    chk(data_rdy === 1'b0, "R9", "rdy after new lower", 32'(data_rdy), 32'd0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge sclk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule